// File: doc/BRIEF.md
# In-Order Store Queue with Four Ring Pointers

This block buffers store operations between dispatch and the data cache write port. Stores receive a slot tag when they are dispatched. Their address, data and byte mask arrive later, possibly out of order. Retirement logic then marks them complete one at a time, oldest first. Completed stores are written to the cache strictly in program order.

The slots form a ring of `DEPTH` entries. Four pointers move around the ring in the same direction: the allocation pointer, the finish pointer, the completion pointer and the commit pointer. Each pointer carries one extra wrap bit. The space between two neighbouring pointers defines a lifecycle region:

- allocated but not yet finished;
- finished but not yet completed;
- completed and waiting to be committed.

A slot becomes empty again once the cache accepts its write. A flush throws away every store that has not completed by moving the allocation and finish pointers back to the completion pointer. Completed stores are kept and still drain to the cache.

Top module: `store_ring_queue`

## Requirements
- R1: After reset the queue is empty, not full, requests no cache write, offers allocation, and offers tag 0.
- R2: Each accepted allocation (`allocValid` high while `allocReady` is high) takes the tag shown on `allocTag`. Tags are handed out as consecutive ring indices modulo `DEPTH`. `allocReady` is low whenever `DEPTH` entries are held or `flush` is high, and a request in that state changes nothing.
- R3: A finish write is stored only when `finTag` lies in the allocated-but-unfinished region, counted from the finish pointer up to the allocation pointer. A finish write to any other tag has no effect on the stored address, data or mask.
- R4: The finish pointer moves forward by at most one entry per clock. It moves over an entry only when that entry was finished in an earlier cycle. An entry finished ahead of an older unfinished one waits. `cmplReady` is high exactly when at least one finished, uncompleted entry exists.
- R5: A completion pulse (`cmplValid`) moves the oldest finished entry into the completed region. A pulse while `cmplReady` is low, or while `flush` is high, has no effect.
- R6: `cwValid` is high exactly when a completed entry exists. `cwAddr`, `cwData` and `cwMask` then show the oldest completed entry and stay stable until `cwReady` is sampled high, which frees that entry.
- R7: A flush sets the allocation and finish pointers equal to the completion pointer. Allocation, finish writes and completion are ignored in the flush cycle. Completed entries stay and still commit, including in the flush cycle itself.
- R8: `queueEmpty` is high when no entry is held. `queueFull` is high when `DEPTH` entries are held, counted from the commit pointer to the allocation pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Dispatch requests a slot |
| allocReady | output | 1 | A slot can be taken this cycle |
| allocTag | output | IDX_W | Tag of the slot the next allocation takes |
| finValid | input | 1 | Address and data for a slot are present |
| finTag | input | IDX_W | Slot the finish write targets |
| finAddr | input | ADDR_W | Store address |
| finData | input | DATA_W | Store data |
| finMask | input | DATA_W/8 | Byte enables |
| cmplValid | input | 1 | Retirement completes the oldest finished store |
| cmplReady | output | 1 | A finished, uncompleted store exists |
| flush | input | 1 | Discard all uncompleted stores |
| cwValid | output | 1 | Cache write request for the oldest completed store |
| cwReady | input | 1 | Cache accepts the write |
| cwAddr | output | ADDR_W | Address of the write (zero when idle) |
| cwData | output | DATA_W | Data of the write (zero when idle) |
| cwMask | output | DATA_W/8 | Byte enables of the write (zero when idle) |
| queueFull | output | 1 | All slots held |
| queueEmpty | output | 1 | No slot held |

## Verification
The hardest case to reach is a flush that arrives while all three regions are populated at the same time:

- at least one completed entry is still waiting on a stalled cache port;
- at least one entry is finished but not yet completed;
- several entries are allocated but not finished;
- the ring has wrapped, so the tags are not at their reset positions.

The directed part of the bench builds this case on purpose. It fills the ring, frees two slots through commits, and reallocates them so the tags wrap. It then finishes two entries, completes only one of them, and flushes. After that it checks that allocation restarts at the completion pointer's tag while the completed store still drains. A random phase then mixes out-of-order and stale finish tags, idle cache cycles and occasional flushes. A behavioural model compares every output on every clock.

// File: rtl/srq_pkg.sv
package srq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // write finish payload into entry wrIdx
    logic rdValid;  // commit request is live; drive payload of rdIdx
  } srq_strobe_t;

endpackage

// File: rtl/srq_datapath.sv
module srq_datapath
  import srq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  srq_strobe_t       strobes,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [MASK_W-1:0] wrMask,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [MASK_W-1:0] rdMask
);

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [MASK_W-1:0] maskMem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.wrEn && (wrIdx == IDX_W'(i))) begin
        addrMem[i] <= wrAddr;
        dataMem[i] <= wrData;
        maskMem[i] <= wrMask;
      end
    end
  end

  always_comb begin
    if (strobes.rdValid) begin
      rdAddr = addrMem[rdIdx];
      rdData = dataMem[rdIdx];
      rdMask = maskMem[rdIdx];
    end else begin
      rdAddr = '0;
      rdData = '0;
      rdMask = '0;
    end
  end

endmodule

// File: rtl/srq_control.sv
module srq_control
  import srq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocValid,
  output logic             allocReady,
  output logic [IDX_W-1:0] allocTag,
  input  logic             finValid,
  input  logic [IDX_W-1:0] finTag,
  input  logic             cmplValid,
  output logic             cmplReady,
  input  logic             flush,
  output logic             cwValid,
  input  logic             cwReady,
  output logic             queueFull,
  output logic             queueEmpty,
  output srq_strobe_t      strobes,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx
);

  localparam int PW = IDX_W + 1;

  logic [PW-1:0] allocPtr, finPtr, cmplPtr, commitPtr;
  logic [PW-1:0] heldCnt, pendCnt;
  logic [IDX_W-1:0] finIdx, tagOff;
  logic [DEPTH-1:0] doneBits;
  logic finInRange, finAccept, advance, allocFire, cmplFire, commitFire;

  assign finIdx  = finPtr[IDX_W-1:0];
  assign heldCnt = allocPtr - commitPtr;
  assign pendCnt = allocPtr - finPtr;
  assign tagOff  = finTag - finIdx;

  assign queueFull  = (heldCnt == PW'(DEPTH));
  assign queueEmpty = (allocPtr == commitPtr);
  assign allocReady = !queueFull && !flush;
  assign allocTag   = allocPtr[IDX_W-1:0];
  assign cmplReady  = (cmplPtr != finPtr);
  assign cwValid    = (commitPtr != cmplPtr);

  assign finInRange = ({1'b0, tagOff} < pendCnt);
  assign finAccept  = finValid && !flush && finInRange;
  assign advance    = !flush && (finPtr != allocPtr) && doneBits[finIdx];
  assign allocFire  = allocValid && allocReady;
  assign cmplFire   = cmplValid && cmplReady && !flush;
  assign commitFire = cwValid && cwReady;

  // Per-entry finished flags for the unfinished region
  for (genvar i = 0; i < DEPTH; i++) begin : g_done
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        doneBits[i] <= 1'b0;
      end else if (advance && (finIdx == IDX_W'(i))) begin
        doneBits[i] <= 1'b0;
      end else if (finAccept && (finTag == IDX_W'(i))) begin
        doneBits[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      allocPtr  <= '0;
      finPtr    <= '0;
      cmplPtr   <= '0;
      commitPtr <= '0;
    end else begin
      if (commitFire) commitPtr <= commitPtr + PW'(1);
      if (flush) begin
        allocPtr <= cmplPtr;
        finPtr   <= cmplPtr;
      end else begin
        if (allocFire) allocPtr <= allocPtr + PW'(1);
        if (advance)   finPtr   <= finPtr + PW'(1);
        if (cmplFire)  cmplPtr  <= cmplPtr + PW'(1);
      end
    end
  end

  assign strobes.wrEn    = finAccept;
  assign strobes.rdValid = cwValid;
  assign wrIdx = finTag;
  assign rdIdx = commitPtr[IDX_W-1:0];

endmodule

// File: rtl/store_ring_queue.sv
module store_ring_queue
  import srq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allocValid,
  output logic              allocReady,
  output logic [IDX_W-1:0]  allocTag,
  input  logic              finValid,
  input  logic [IDX_W-1:0]  finTag,
  input  logic [ADDR_W-1:0] finAddr,
  input  logic [DATA_W-1:0] finData,
  input  logic [MASK_W-1:0] finMask,
  input  logic              cmplValid,
  output logic              cmplReady,
  input  logic              flush,
  output logic              cwValid,
  input  logic              cwReady,
  output logic [ADDR_W-1:0] cwAddr,
  output logic [DATA_W-1:0] cwData,
  output logic [MASK_W-1:0] cwMask,
  output logic              queueFull,
  output logic              queueEmpty
);

  srq_strobe_t      strobes;
  logic [IDX_W-1:0] wrIdx, rdIdx;

  srq_control #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocReady(allocReady), .allocTag(allocTag),
    .finValid(finValid), .finTag(finTag),
    .cmplValid(cmplValid), .cmplReady(cmplReady),
    .flush(flush),
    .cwValid(cwValid), .cwReady(cwReady),
    .queueFull(queueFull), .queueEmpty(queueEmpty),
    .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  srq_datapath #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)
  ) u_data (
    .clk(clk), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrAddr(finAddr), .wrData(finData), .wrMask(finMask),
    .rdAddr(cwAddr), .rdData(cwData), .rdMask(cwMask)
  );

endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              allocReady,
  input logic              flush,
  input logic              cmplReady,
  input logic              cwValid,
  input logic              cwReady,
  input logic [ADDR_W-1:0] cwAddr,
  input logic [DATA_W-1:0] cwData,
  input logic              queueFull,
  input logic              queueEmpty
);

  a_r2_full_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    queueFull |-> !allocReady);

  a_r8_full_empty_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(queueFull && queueEmpty));

  a_r8_empty_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    queueEmpty |-> !cwValid);

  a_r6_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (cwValid && !cwReady) |=> (cwValid && $stable(cwAddr) && $stable(cwData)));

  a_r7_flush_clears_finished: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !cmplReady);

  a_r7_flush_keeps_completed: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && cwValid && !cwReady) |=> cwValid);

endmodule

bind store_ring_queue srq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .allocReady(allocReady), .flush(flush),
  .cmplReady(cmplReady), .cwValid(cwValid), .cwReady(cwReady),
  .cwAddr(cwAddr), .cwData(cwData), .queueFull(queueFull), .queueEmpty(queueEmpty)
);

// File: tb/store_ring_queue_test.sv
`timescale 1ns/1ps
module store_ring_queue_test;

  localparam int N = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic allocValid = 0, finValid = 0, cmplValid = 0, flush = 0, cwReady = 0;
  logic [2:0]  finTag = 0;
  logic [31:0] finAddr = 0;
  logic [63:0] finData = 0;
  logic [7:0]  finMask = 0;
  logic allocReady, cmplReady, cwValid, queueFull, queueEmpty;
  logic [2:0]  allocTag;
  logic [31:0] cwAddr;
  logic [63:0] cwData;
  logic [7:0]  cwMask;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  store_ring_queue uut (
    .clk(clk), .rst_n(rst_n), .allocValid(allocValid), .allocReady(allocReady),
    .allocTag(allocTag), .finValid(finValid), .finTag(finTag), .finAddr(finAddr),
    .finData(finData), .finMask(finMask), .cmplValid(cmplValid), .cmplReady(cmplReady),
    .flush(flush), .cwValid(cwValid), .cwReady(cwReady), .cwAddr(cwAddr),
    .cwData(cwData), .cwMask(cwMask), .queueFull(queueFull), .queueEmpty(queueEmpty)
  );

  // Behavioural model: running counts per pointer, slot contents
  int mAlloc = 0, mFin = 0, mCmpl = 0, mCommit = 0;
  logic [31:0] mAddr [N];
  logic [63:0] mData [N];
  logic [7:0]  mMask [N];
  bit          mDone [N];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mAlloc = 0; mFin = 0; mCmpl = 0; mCommit = 0;
      for (int i = 0; i < N; i++) mDone[i] = 0;
    end else begin
      int pend, off, head;
      bit adv, aFire, cFire, wFire;
      pend  = mAlloc - mFin;
      head  = mFin % N;
      adv   = !flush && (pend > 0) && mDone[head];
      aFire = allocValid && !flush && ((mAlloc - mCommit) < N);
      cFire = cmplValid && !flush && (mCmpl != mFin);
      wFire = cwReady && (mCommit != mCmpl);
      if (wFire) mCommit++;
      if (flush) begin
        mAlloc = mCmpl; mFin = mCmpl;
        for (int i = 0; i < N; i++) mDone[i] = 0;
      end else begin
        off = (int'(finTag) - head + N) % N;
        if (finValid && off < pend) begin
          mAddr[finTag] = finAddr; mData[finTag] = finData;
          mMask[finTag] = finMask; mDone[finTag] = 1;
        end
        if (adv) begin mDone[head] = 0; mFin++; end
        if (aFire) mAlloc++;
        if (cFire) mCmpl++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit fullE;
      fullE = (mAlloc - mCommit) == N;
      chk("R2 allocReady", 64'(allocReady), 64'(!fullE && !flush));
      chk("R2 allocTag", 64'(allocTag), 64'(mAlloc % N));
      chk("R8 queueFull", 64'(queueFull), 64'(fullE));
      chk("R8 queueEmpty", 64'(queueEmpty), 64'(mAlloc == mCommit));
      chk("R4 cmplReady", 64'(cmplReady), 64'(mCmpl != mFin));
      chk("R6 cwValid", 64'(cwValid), 64'(mCommit != mCmpl));
      if (mCommit != mCmpl) begin
        chk("R6 cwAddr", 64'(cwAddr), 64'(mAddr[mCommit % N]));
        chk("R6 cwData", cwData, mData[mCommit % N]);
        chk("R6 cwMask", 64'(cwMask), 64'(mMask[mCommit % N]));
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic setFin(input logic [2:0] t, input logic [31:0] a);
    finValid = 1; finTag = t; finAddr = a;
    finData = {a, ~a}; finMask = 8'(t) ^ 8'hA5;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 empty", 64'(queueEmpty), 1);
    chk("R1 full", 64'(queueFull), 0);
    chk("R1 cwValid", 64'(cwValid), 0);
    chk("R1 allocTag", 64'(allocTag), 0);
    chk("R1 allocReady", 64'(allocReady), 1);

    // R2 fill the ring
    allocValid = 1; repeat (8) cyc(); allocValid = 0; #1;
    chk("R2 full after 8", 64'(queueFull), 1);
    chk("R2 allocReady when full", 64'(allocReady), 0);
    allocValid = 1; cyc(); allocValid = 0; #1;
    chk("R2 request while full ignored", 64'(allocTag), 0);

    // R4 out-of-order finish waits for the older entry
    setFin(3'd1, 32'h1000_0010); cyc(); finValid = 0;
    cyc(); cyc(); #1;
    chk("R4 waits for tag 0", 64'(cmplReady), 0);
    setFin(3'd0, 32'h1000_0000); cyc(); finValid = 0;
    cyc(); cyc(); #1;
    chk("R4 run advanced", 64'(cmplReady), 1);

    // R3 stale finish to tag 0 (already past finish pointer)
    setFin(3'd0, 32'hDEAD_BEEF); cyc(); finValid = 0;

    // R5/R6 complete one, stall the cache port
    cmplValid = 1; cyc(); cmplValid = 0; #1;
    chk("R3 stale finish ignored", 64'(cwAddr), 64'h1000_0000);
    cyc(); cyc(); #1;
    chk("R6 held while not ready", 64'(cwAddr), 64'h1000_0000);
    cmplValid = 1; cyc(); cyc(); cmplValid = 0;
    cwReady = 1; cyc(); cyc(); cwReady = 0; #1;
    chk("R5 extra completion ignored", 64'(cwValid), 0);
    chk("R5 entries remain", 64'(queueEmpty), 0);

    // R7 flush with all regions populated after a wrap
    allocValid = 1; cyc(); cyc(); allocValid = 0;
    setFin(3'd2, 32'h1000_0020); cyc();
    setFin(3'd3, 32'h1000_0030); cyc(); finValid = 0;
    cyc(); cyc();
    cmplValid = 1; cyc(); cmplValid = 0;
    flush = 1; allocValid = 1; cmplValid = 1; cyc();
    flush = 0; allocValid = 0; cmplValid = 0; #1;
    chk("R7 alloc restarts at completion tag", 64'(allocTag), 3);
    chk("R7 finished work discarded", 64'(cmplReady), 0);
    chk("R7 completed entry kept", 64'(cwValid), 1);
    chk("R7 completed payload", 64'(cwAddr), 64'h1000_0020);
    cwReady = 1; cyc(); cwReady = 0; #1;
    chk("R7 drained to empty", 64'(queueEmpty), 1);

    // Random mix compared against the model every clock
    for (int k = 0; k < 3000; k++) begin
      allocValid = ($urandom_range(0, 99) < 60);
      finValid   = ($urandom_range(0, 99) < 55);
      finTag     = 3'($urandom_range(0, 7));
      finAddr    = $urandom;
      finData    = {$urandom, $urandom};
      finMask    = 8'($urandom);
      cmplValid  = ($urandom_range(0, 99) < 40);
      cwReady    = ($urandom_range(0, 99) < 45);
      flush      = ($urandom_range(0, 99) < 2);
      cyc();
    end
    allocValid = 0; finValid = 0; cmplValid = 0; flush = 0; cwReady = 0;
    cyc(); cyc();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule